// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block gives the fetch stage a predicted destination for the instruction at the current fetch address. It holds a small direct-mapped table. Each slot has a valid flag, an address tag and a destination address. The lookup side takes the fetch PC and a taken/not-taken bit from a separate direction predictor. It reports whether the PC is in the table and produces the address to fetch next. That address is the stored destination when the PC hits and the direction bit says taken. In every other case it is the sequential address PC+4.

The install side is driven from the execute stage. Every branch or jump that resolves there writes its slot, whatever its outcome. A not-taken branch writes the destination it would have had if taken, so a later taken prediction can use it. If a stored destination turns out wrong, the execute stage writes the same PC again with the correct value, and the old one is overwritten. A bubble, or any cycle that carries no resolved branch, keeps the install strobe low and leaves the table untouched.

The table holds 16 slots, selected by PC bits 5..2. The tag is PC bits 31..6. Lookups read the table without a clock edge in between. A write takes effect at the clock edge that ends its cycle.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous reset, or while nothing has been installed since reset, every lookup reports a miss (lk_hit = 0) and lk_next_pc = lk_pc + 4.
- R2: A lookup hits only when the slot selected by lk_pc[5:2] is valid and its stored tag equals lk_pc[31:6]; a different tag at the same slot is a miss.
- R3: On a hit with lk_taken = 1, lk_next_pc equals the destination stored in that slot.
- R4: On a hit with lk_taken = 0, lk_hit is still 1 and lk_next_pc = lk_pc + 4.
- R5: On a miss, lk_next_pc = lk_pc + 4 regardless of lk_taken.
- R6: A cycle with wr_en = 1 installs slot wr_pc[5:2] with tag wr_pc[31:6] and destination wr_target, marking it valid; a lookup of wr_pc in the next cycle hits.
- R7: Writing an already present PC again replaces its destination with the new wr_target.
- R8: With wr_en = 0 the wr_pc and wr_target inputs have no effect on the table.
- R9: A write does not change the lookup result of its own cycle, even at the same slot; the new content appears from the following cycle.
- R10: Two PCs with the same bits 5..2 and different upper bits evict each other; PCs at different slots are kept independently.
- R11: PC bits 1..0 are neither used for the slot nor compared in the tag, so lk_pc = 0x1000_0012 hits an entry installed for 0x1000_0010.
- R12: The sequential address wraps modulo 2^32 (lk_pc = 0xFFFF_FFFC gives 0x0000_0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears all valid flags |
| lk_pc | input | 32 | Fetch-stage PC being looked up |
| lk_taken | input | 1 | Direction prediction for lk_pc (1 = taken) |
| lk_hit | output | 1 | Valid slot with matching tag |
| lk_next_pc | output | 32 | Next fetch address |
| wr_en | input | 1 | A resolved branch or jump is present this cycle |
| wr_pc | input | 32 | PC of the resolved branch or jump |
| wr_target | input | 32 | Its computed destination (as if taken) |

## Verification
An install from the execute stage and a lookup from the fetch stage can fall in the same cycle, including at the same slot and with the same PC. The bench provokes this by driving a write and a matching lookup together. It expects the old content (a miss, or the previous destination) in that cycle and the new content in the next one. Same-slot lookups under a different tag, and lookups with offset bits set, are judged in the cycles that follow. This shows that the overlap neither corrupts a neighbour nor widens a match.

// File: rtl/btb_pkg.sv
// Shared types for the branch target buffer.
package btb_pkg;

    // Source chosen for the next fetch address.
    typedef enum logic {
        SEL_SEQ    = 1'b0,
        SEL_TARGET = 1'b1
    } nxt_sel_e;

endpackage

// File: rtl/btb_addr_split.sv
// Splits an instruction address into slot index and tag.
// Assumes aligned instructions: the low OFS_W bits are dropped, not compared.
module btb_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFS_W  = 2
) (
    input  logic [ADDR_W-1:0]             pc,
    output logic [IDX_W-1:0]              idx,
    output logic [ADDR_W-IDX_W-OFS_W-1:0] tag
);
    localparam int TAG_LSB = IDX_W + OFS_W;

    logic [OFS_W-1:0] unused_ofs;

    // Field extraction.
    always_comb begin
        idx        = pc[TAG_LSB-1:OFS_W];
        tag        = pc[ADDR_W-1:TAG_LSB];
        unused_ofs = pc[OFS_W-1:0];
    end
endmodule

// File: rtl/btb_entry_array.sv
// Storage of valid flags, tags and destinations, one slot per index.
// Reads are combinational from registered state, so a write lands at the
// clock edge and is invisible to the lookup of its own cycle.
// Only valid flags are reset; tag and destination need no reset.
module btb_entry_array #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_target
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [ADDR_W-1:0]  target_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic sel_w;
        assign sel_w = wr_en && (wr_idx == IDX_W'(e));

        // Valid flag: cleared by reset, set by an install.
        always_ff @(posedge clk) begin
            if (!rst_n)     valid_q[e] <= 1'b0;
            else if (sel_w) valid_q[e] <= 1'b1;
        end

        // Tag and destination capture on install.
        always_ff @(posedge clk) begin
            if (rst_n && sel_w) begin
                tag_q[e]    <= wr_tag;
                target_q[e] <= wr_target;
            end
        end
    end

    // Read port.
    always_comb begin
        rd_valid  = valid_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_target = target_q[rd_idx];
    end
endmodule

// File: rtl/btb_next_sel.sv
// Hit detection and next fetch address selection.
// Redirects only when a hit coincides with a taken direction bit.
module btb_next_sel
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 26,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [TAG_W-1:0]  pc_tag,
    input  logic              taken,
    input  logic              slot_valid,
    input  logic [TAG_W-1:0]  slot_tag,
    input  logic [ADDR_W-1:0] slot_target,
    output logic              hit,
    output logic [ADDR_W-1:0] next_pc
);
    nxt_sel_e sel;

    // Tag match and source choice.
    always_comb begin
        hit     = slot_valid && (slot_tag == pc_tag);
        sel     = (hit && taken) ? SEL_TARGET : SEL_SEQ;
        next_pc = (sel == SEL_TARGET) ? slot_target : pc + ADDR_W'(STEP);
    end
endmodule

// File: rtl/btb_predictor.sv
// Direct-mapped branch target buffer, top level.
// Lookup side: fetch PC plus a direction bit gives a hit flag and the next PC.
// Install side: every resolved branch/jump (wr_en high) writes its slot.
// Assumes wr_en is low for bubbles and non-branch cycles.
module btb_predictor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic              lk_taken,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_target
);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam int STEP  = 1 << OFS_W;

    logic [IDX_W-1:0]  lk_idx, wr_idx;
    logic [TAG_W-1:0]  lk_tag, wr_tag;
    logic              slot_valid;
    logic [TAG_W-1:0]  slot_tag;
    logic [ADDR_W-1:0] slot_target;

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_lk_split (
        .pc  (lk_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_wr_split (
        .pc  (wr_pc),
        .idx (wr_idx),
        .tag (wr_tag)
    );

    btb_entry_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_target (wr_target),
        .rd_idx    (lk_idx),
        .rd_valid  (slot_valid),
        .rd_tag    (slot_tag),
        .rd_target (slot_target)
    );

    btb_next_sel #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .STEP(STEP)) u_sel (
        .pc          (lk_pc),
        .pc_tag      (lk_tag),
        .taken       (lk_taken),
        .slot_valid  (slot_valid),
        .slot_tag    (slot_tag),
        .slot_target (slot_target),
        .hit         (lk_hit),
        .next_pc     (lk_next_pc)
    );
endmodule

// File: rtl/btb_predictor_chk.sv
// Port-level properties of btb_predictor, attached by bind.
// Tracks whether any install happened since reset to judge cold misses.
module btb_predictor_chk #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              lk_taken,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_next_pc,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_pc,
    input logic [ADDR_W-1:0] wr_target
);
    logic              any_wr;
    logic [ADDR_W-1:0] seq_pc;

    assign seq_pc = lk_pc + ADDR_W'(1 << OFS_W);

    // Records the first install after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     any_wr <= 1'b0;
        else if (wr_en) any_wr <= 1'b1;
    end

    assert_cold_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |-> !lk_hit);

    assert_seq_when_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_taken |-> lk_next_pc == seq_pc);

    assert_seq_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_next_pc == seq_pc);

    assert_install_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && lk_pc == $past(wr_pc)) |-> lk_hit);

    assert_install_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && lk_pc == $past(wr_pc) && lk_taken)
            |-> lk_next_pc == $past(wr_target));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_taken = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_next_pc;
    logic        wr_en = 1'b0;
    logic [31:0] wr_pc = '0;
    logic [31:0] wr_target = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    btb_predictor dut (.*);

    typedef struct packed {
        logic        we;
        logic [31:0] wpc;
        logic [31:0] wtgt;
        logic [31:0] lpc;
        logic        ltk;
        logic        ehit;
        logic [31:0] enext;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0, 32'h0, 32'h1000_0010, 1'b1, 1'b0, 32'h1000_0014, 8'd5},                 // R5 cold
        '{1'b1, 32'h1000_0010, 32'h1000_0200, 32'h1000_0010, 1'b1, 1'b0, 32'h1000_0014, 8'd9}, // R9 same cycle
        '{1'b0, 32'h0, 32'h0, 32'h1000_0010, 1'b1, 1'b1, 32'h1000_0200, 8'd3},                 // R3 / R6
        '{1'b0, 32'h0, 32'h0, 32'h1000_0010, 1'b0, 1'b1, 32'h1000_0014, 8'd4},                 // R4
        '{1'b0, 32'h0, 32'h0, 32'h2000_0010, 1'b1, 1'b0, 32'h2000_0014, 8'd2},                 // R2 tag differs
        '{1'b1, 32'h1000_0010, 32'h1000_0300, 32'h1000_0012, 1'b1, 1'b1, 32'h1000_0200, 8'd11},// R11 + R9
        '{1'b0, 32'h0, 32'h0, 32'h1000_0010, 1'b1, 1'b1, 32'h1000_0300, 8'd7},                 // R7 overwrite
        '{1'b1, 32'h2000_0010, 32'h2000_0040, 32'h1000_0010, 1'b1, 1'b1, 32'h1000_0300, 8'd9}, // R9
        '{1'b0, 32'h0, 32'h0, 32'h1000_0010, 1'b1, 1'b0, 32'h1000_0014, 8'd10},                // R10 evicted
        '{1'b0, 32'h0, 32'h0, 32'h2000_0010, 1'b1, 1'b1, 32'h2000_0040, 8'd10},                // R10 new owner
        '{1'b1, 32'h1000_003C, 32'h1000_0000, 32'h1000_003C, 1'b1, 1'b0, 32'h1000_0040, 8'd9}, // R9 slot 15
        '{1'b0, 32'h0, 32'h0, 32'h1000_003C, 1'b1, 1'b1, 32'h1000_0000, 8'd6},                 // R6 backward
        '{1'b0, 32'h0, 32'h0, 32'h2000_0010, 1'b1, 1'b1, 32'h2000_0040, 8'd10},                // R10 independent
        '{1'b1, 32'hFFFF_FFFC, 32'h0000_0100, 32'hFFFF_FFFC, 1'b1, 1'b0, 32'h0000_0000, 8'd12},// R12 wrap
        '{1'b0, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b0, 1'b1, 32'h0000_0000, 8'd12},                // R12 / R4
        '{1'b0, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b1, 1'b1, 32'h0000_0100, 8'd3},                 // R3
        '{1'b0, 32'h1000_0014, 32'h0000_0055, 32'h1000_0014, 1'b1, 1'b0, 32'h1000_0018, 8'd8}, // R8 data, no strobe
        '{1'b0, 32'h0, 32'h0, 32'h1000_0014, 1'b1, 1'b0, 32'h1000_0018, 8'd8}                  // R8 still absent
    };

    task automatic check(input string req, input logic ah, input logic eh,
                         input logic [31:0] an, input logic [31:0] en);
        checks++;
        if (ah !== eh || an !== en) begin
            fails++;
            $display("FAIL %s: hit=%0b next=%08h expected hit=%0b next=%08h", req, ah, an, eh, en);
        end
    endtask

    // One cycle: drive at falling edge, sample 5 ns later, write lands at next rising edge.
    task automatic step(input logic we, input logic [31:0] wpc, input logic [31:0] wtgt,
                        input logic [31:0] lpc, input logic ltk,
                        input logic eh, input logic [31:0] en, input string req);
        @(negedge clk);
        wr_en = we; wr_pc = wpc; wr_target = wtgt; lk_pc = lpc; lk_taken = ltk;
        #5;
        check(req, lk_hit, eh, lk_next_pc, en);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state, lookup during reset and just after
        @(negedge clk); lk_pc = 32'h1000_0010; lk_taken = 1'b1; #5;
        check("R1 in reset", lk_hit, 1'b0, lk_next_pc, 32'h1000_0014);
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 0, 0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0004, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].wpc, VEC[i].wtgt, VEC[i].lpc, VEC[i].ltk,
                 VEC[i].ehit, VEC[i].enext, $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        // R1: mid-run reset clears installed entries
        @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 0, 0, 32'h2000_0010, 1'b1, 1'b0, 32'h2000_0014, "R1 reset clears");
        step(1'b0, 0, 0, 32'hFFFF_FFFC, 1'b1, 1'b0, 32'h0000_0000, "R1 reset clears wrap");

        // R6 / R2: not-taken install stores would-be target; tag with low bits set never matches other tag
        step(1'b1, 32'h0000_0044, 32'h0000_0010, 32'h0000_0044, 1'b0, 1'b0, 32'h0000_0048, "R9 install");
        step(1'b0, 0, 0, 32'h0000_0044, 1'b1, 1'b1, 32'h0000_0010, "R6 install");
        step(1'b0, 0, 0, 32'h0000_0084, 1'b1, 1'b0, 32'h0000_0088, "R2 alias slot");

        @(negedge clk); wr_en = 1'b0;
        finish_run();
    end
endmodule